// File: doc/BRIEF.md
# Parallel SAR Converter Read Controller

This block sits on the host side of a 16-bit successive-approximation converter that has a parallel output bus. It runs from a fast system clock and generates every control line the converter needs: a free-running conversion clock, an active-low start strobe, an active-low chip select, an active-low read strobe and a byte-lane select. When a request arrives, the block starts one conversion. It then waits for the converter's busy line, which it brings in through two flops, to fall. After that it fetches the result.

The result is fetched in one of two ways. In word mode a single 16-bit read captures the whole result. In byte mode two reads on the low eight lanes fetch the low half first and then the high half, and the block joins them into one word. The finished word appears on a 16-bit output with a one-cycle valid pulse.

Every strobe width, setup time, acquisition gap and read blackout is a parameter counted in system-clock cycles. If busy does not fall within a set number of conversion-clock rising edges, an error flag is raised and the block returns to idle.

Top module: `adc_par_reader`

## Requirements
- R1: During and right after reset, the start strobe, chip select and read strobe are high. The byte select, the valid pulse, the error flag and the conversion clock are low.
- R2: The conversion clock runs without stopping. Each high phase and each low phase lasts exactly `CCLK_HALF` system cycles.
- R3: Chip select is low at least one cycle before the start strobe falls. The strobe stays low for exactly `STRB_LOW` cycles. It falls exactly `STRB_SETUP` cycles before a conversion-clock rising edge.
- R4: A start strobe falls only after busy has been low, the read strobe high and the start strobe high for at least max(`ACQ_QUIET`, `PRE_QUIET`) cycles in a row.
- R5: In word mode (mode input 0) there is exactly one read per conversion. The read strobe is low for exactly `RD_LOW` cycles with chip select low and byte select 0. The result is all 16 bus lanes as they stand at the end of that read.
- R6: In byte mode (mode input 1), the first read has byte select 0 and takes result bits 7..0 from lanes 7..0. The second read has byte select 1 and takes result bits 15..8 from lanes 7..0. Lanes 15..8 are ignored. The read strobe stays high for `RD_HIGH` cycles between the two reads. Byte select does not change while the read strobe is low.
- R7: A read starts only after the synchronised busy line has been seen high and then low, and at least `POST_QUIET` cycles after the start strobe fell. No read overlaps a low start strobe.
- R8: Each completed conversion gives exactly one valid pulse, one cycle wide, with the joined result on the sample output in that cycle.
- R9: A request made while a conversion or read is in progress is ignored. It starts no further conversion and gives no further valid pulse.
- R10: If busy has not fallen by the `TIMEOUT_CCLK`-th conversion-clock rising edge after the strobe, the error flag goes high. In that case no read happens, chip select returns high and the block goes back to idle. The flag clears when the next request is accepted.
- R11: The mode input is captured when a request is accepted. A change to it later in the conversion does not affect that conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Conversion request, taken only when idle |
| byte_mode_i | input | 1 | 0: one 16-bit read, 1: two 8-bit reads |
| busy_i | input | 1 | Converter busy line, asynchronous |
| db_i | input | 16 | Converter data bus |
| cclk_o | output | 1 | Conversion clock to the converter |
| convst_n_o | output | 1 | Start strobe, active low |
| cs_n_o | output | 1 | Chip select, active low |
| rd_n_o | output | 1 | Read strobe, active low |
| byte_o | output | 1 | Byte-lane select for byte mode |
| sample_o | output | 16 | Joined conversion result |
| valid_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Busy timeout flag |

## Verification
The bench builds the block with a 10 ns system clock and `CCLK_HALF`=5, which gives the fastest allowed 100 ns conversion clock. The other settings are `STRB_LOW`=3, `STRB_SETUP`=2, `RD_LOW`=5, `RD_HIGH`=3, `POST_QUIET`=2, `PRE_QUIET`=13 and `ACQ_QUIET`=41. With these values the converter model can check each window exactly in nanoseconds, and it can check back-to-back conversions right at the acquisition limit. `TIMEOUT_CCLK`=24 lies just above the 17 rising edges that a conversion takes. This means a converter whose busy line is held high trips the error path within a few hundred cycles, and the next conversion then shows the flag clearing.

// File: rtl/adc_par_reader.sv
`timescale 1ns/1ps
module adc_par_reader #(
  parameter int CCLK_HALF    = 5,
  parameter int STRB_LOW     = 3,
  parameter int STRB_SETUP   = 2,
  parameter int RD_LOW       = 5,
  parameter int RD_HIGH      = 3,
  parameter int PRE_QUIET    = 13,
  parameter int POST_QUIET   = 2,
  parameter int ACQ_QUIET    = 41,
  parameter int TIMEOUT_CCLK = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_i,
  input  logic        byte_mode_i,
  input  logic        busy_i,
  input  logic [15:0] db_i,
  output logic        cclk_o,
  output logic        convst_n_o,
  output logic        cs_n_o,
  output logic        rd_n_o,
  output logic        byte_o,
  output logic [15:0] sample_o,
  output logic        valid_o,
  output logic        err_o
);

  localparam int QUIET = (ACQ_QUIET > PRE_QUIET) ? ACQ_QUIET : PRE_QUIET;
  localparam int TM_A  = (STRB_LOW > POST_QUIET) ? STRB_LOW : POST_QUIET;
  localparam int TM_B  = (RD_LOW > RD_HIGH) ? RD_LOW : RD_HIGH;
  localparam int TMAX  = (TM_A > TM_B) ? TM_A : TM_B;
  localparam int DW    = $clog2(CCLK_HALF + 1);
  localparam int QW    = $clog2(QUIET + 1);
  localparam int TW    = $clog2(TMAX + 1);
  localparam int CTW   = $clog2(TIMEOUT_CCLK + 1);
  localparam int SLOT  = CCLK_HALF - 1 - STRB_SETUP;

  typedef enum logic [2:0] {S_IDLE, S_ALIGN, S_STRB, S_WAIT, S_RD, S_GAP} state_t;

  state_t          st;
  logic [DW-1:0]   cdiv;
  logic [1:0]      bsync;
  logic [QW-1:0]   quiet;
  logic [TW-1:0]   tmr;
  logic [CTW-1:0]  ccnt;
  logic [7:0]      lo_q;
  logic            mode_q, hi_q, seen_hi;
  logic            busy_s, cclk_rise, launch_slot, quiet_ok, post_ok;
  logic [TW-1:0]   tmr_nx;
  logic [CTW-1:0]  ccnt_nx;

  assign busy_s      = bsync[1];
  assign cclk_rise   = !cclk_o && (cdiv == DW'(CCLK_HALF - 1));
  assign launch_slot = !cclk_o && (cdiv == DW'(SLOT));
  assign quiet_ok    = (quiet == QW'(QUIET));
  assign post_ok     = (tmr >= TW'(POST_QUIET));
  assign tmr_nx      = (tmr == TW'(TMAX)) ? tmr : tmr + 1'b1;
  assign ccnt_nx     = (cclk_rise && ccnt != CTW'(TIMEOUT_CCLK)) ? ccnt + 1'b1 : ccnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cdiv   <= '0;
      cclk_o <= 1'b0;
    end else if (cdiv == DW'(CCLK_HALF - 1)) begin
      cdiv   <= '0;
      cclk_o <= ~cclk_o;
    end else begin
      cdiv   <= cdiv + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bsync <= '0;
    else        bsync <= {bsync[0], busy_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      quiet <= '0;
    else if (busy_s || !rd_n_o || !convst_n_o || st == S_STRB || st == S_WAIT)
      quiet <= '0;
    else if (!quiet_ok)
      quiet <= quiet + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      convst_n_o <= 1'b1;
      cs_n_o     <= 1'b1;
      rd_n_o     <= 1'b1;
      byte_o     <= 1'b0;
      sample_o   <= '0;
      valid_o    <= 1'b0;
      err_o      <= 1'b0;
      tmr        <= '0;
      ccnt       <= '0;
      lo_q       <= '0;
      mode_q     <= 1'b0;
      hi_q       <= 1'b0;
      seen_hi    <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      case (st)
        S_IDLE:
          if (req_i) begin
            mode_q <= byte_mode_i;
            err_o  <= 1'b0;
            cs_n_o <= 1'b0;
            st     <= S_ALIGN;
          end
        S_ALIGN:
          if (quiet_ok && launch_slot) begin
            convst_n_o <= 1'b0;
            tmr        <= TW'(1);
            ccnt       <= '0;
            seen_hi    <= 1'b0;
            st         <= S_STRB;
          end
        S_STRB: begin
          tmr  <= tmr_nx;
          ccnt <= ccnt_nx;
          if (tmr == TW'(STRB_LOW)) begin
            convst_n_o <= 1'b1;
            st         <= S_WAIT;
          end
        end
        S_WAIT: begin
          tmr  <= tmr_nx;
          ccnt <= ccnt_nx;
          if (busy_s) seen_hi <= 1'b1;
          if (seen_hi && !busy_s && post_ok) begin
            rd_n_o <= 1'b0;
            byte_o <= 1'b0;
            hi_q   <= 1'b0;
            tmr    <= TW'(1);
            st     <= S_RD;
          end else if (ccnt == CTW'(TIMEOUT_CCLK)) begin
            err_o  <= 1'b1;
            cs_n_o <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_RD: begin
          tmr <= tmr_nx;
          if (tmr == TW'(RD_LOW)) begin
            rd_n_o <= 1'b1;
            tmr    <= TW'(1);
            if (mode_q && !hi_q) begin
              lo_q   <= db_i[7:0];
              hi_q   <= 1'b1;
              byte_o <= 1'b1;
              st     <= S_GAP;
            end else begin
              sample_o <= mode_q ? {db_i[7:0], lo_q} : db_i;
              valid_o  <= 1'b1;
              cs_n_o   <= 1'b1;
              byte_o   <= 1'b0;
              st       <= S_IDLE;
            end
          end
        end
        S_GAP: begin
          tmr <= tmr_nx;
          if (tmr == TW'(RD_HIGH)) begin
            rd_n_o <= 1'b0;
            tmr    <= TW'(1);
            st     <= S_RD;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module adc_par_reader_chk #(
  parameter int CCLK_HALF = 5,
  parameter int STRB_LOW  = 3,
  parameter int RD_LOW    = 5
) (
  input logic clk,
  input logic rst_n,
  input logic cclk_o,
  input logic convst_n_o,
  input logic cs_n_o,
  input logic rd_n_o,
  input logic byte_o,
  input logic valid_o,
  input logic err_o
);

  logic [15:0] ph, slow, rlow;
  logic        prev_cclk, seen_edge;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph <= '0; slow <= '0; rlow <= '0; prev_cclk <= 1'b0; seen_edge <= 1'b0;
    end else begin
      prev_cclk <= cclk_o;
      ph        <= (cclk_o != prev_cclk) ? 16'd1 : ph + 16'd1;
      seen_edge <= seen_edge | (cclk_o != prev_cclk);
      slow      <= convst_n_o ? 16'd0 : slow + 16'd1;
      rlow      <= rd_n_o ? 16'd0 : rlow + 16'd1;
    end

  p_cclk_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk_o != prev_cclk) && seen_edge |-> ph == 16'(CCLK_HALF));
  p_strobe_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !convst_n_o |-> !cs_n_o);
  p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(convst_n_o) |-> slow == 16'(STRB_LOW));
  p_read_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o |-> !cs_n_o);
  p_read_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n_o) |-> rlow == 16'(RD_LOW));
  p_byte_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n_o && $past(!rd_n_o) |-> $stable(byte_o));
  p_no_read_in_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !convst_n_o |-> rd_n_o);
  p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  p_err_no_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o);

endmodule

bind adc_par_reader adc_par_reader_chk #(
  .CCLK_HALF(CCLK_HALF), .STRB_LOW(STRB_LOW), .RD_LOW(RD_LOW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cclk_o(cclk_o), .convst_n_o(convst_n_o),
  .cs_n_o(cs_n_o), .rd_n_o(rd_n_o), .byte_o(byte_o), .valid_o(valid_o),
  .err_o(err_o)
);

// File: tb/adc_par_reader_test.sv
`timescale 1ns/1ps
module adc_par_reader_test;
  localparam int CLK_NS  = 10;
  localparam int H       = 5;
  localparam int S_LOW   = 3;
  localparam int S_SETUP = 2;
  localparam int R_LOW   = 5;
  localparam int R_HIGH  = 3;
  localparam int PRE     = 13;
  localparam int POST    = 2;
  localparam int ACQ     = 41;
  localparam int TMO     = 24;
  localparam int QUIET   = (ACQ > PRE) ? ACQ : PRE;

  logic clk = 0, rst_n = 0, req = 0, bmode = 0, busy_m = 0, stuck = 0;
  logic [15:0] db, sample, out_reg = 16'h0, model_code = 16'h0;
  logic cclk, convst_n, cs_n, rd_n, byte_sel, valid, err;

  int n_chk = 0, n_err = 0;
  int conv_count = 0, handled = 0, rd_count = 0, valid_count = 0, rise_cnt = 0;
  logic [1:0] byte_hist = 2'b00;
  real t_cv_fall = -1.0e6, t_rd_fall = -1.0e6, t_rd_rise = -1.0e6, t_busy_fall = -1.0e6;
  bit finished = 0;

  adc_par_reader #(
    .CCLK_HALF(H), .STRB_LOW(S_LOW), .STRB_SETUP(S_SETUP), .RD_LOW(R_LOW),
    .RD_HIGH(R_HIGH), .PRE_QUIET(PRE), .POST_QUIET(POST), .ACQ_QUIET(ACQ),
    .TIMEOUT_CCLK(TMO)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .byte_mode_i(bmode), .busy_i(busy_m),
    .db_i(db), .cclk_o(cclk), .convst_n_o(convst_n), .cs_n_o(cs_n), .rd_n_o(rd_n),
    .byte_o(byte_sel), .sample_o(sample), .valid_o(valid), .err_o(err)
  );

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // converter model
  assign db = (!cs_n && !rd_n) ? (byte_sel ? {8'hA5, out_reg[15:8]} : out_reg) : 16'h0F0F;

  always @(negedge convst_n) if (rst_n) begin
    chk(cs_n == 1'b0, "R3 chip select low at strobe fall", int'(cs_n), 0);
    chk(busy_m == 1'b0, "R4 strobe while converter busy", int'(busy_m), 0);
    chk(($realtime - t_rd_rise) >= real'(QUIET*CLK_NS), "R4 read-to-strobe gap ns",
        int'($realtime - t_rd_rise), QUIET*CLK_NS);
    chk(($realtime - t_busy_fall) >= real'(ACQ*CLK_NS), "R4 acquisition gap ns",
        int'($realtime - t_busy_fall), ACQ*CLK_NS);
    t_cv_fall = $realtime;
    conv_count++;
  end

  always @(posedge convst_n) if (conv_count > 0)
    chk(int'($realtime - t_cv_fall) == S_LOW*CLK_NS, "R3 strobe low ns",
        int'($realtime - t_cv_fall), S_LOW*CLK_NS);

  always @(posedge cclk) begin
    if (conv_count != handled) begin
      handled = conv_count;
      chk(int'($realtime - t_cv_fall) == S_SETUP*CLK_NS, "R3 strobe setup ns",
          int'($realtime - t_cv_fall), S_SETUP*CLK_NS);
      rise_cnt = 1;
      busy_m <= #1 1'b1;
    end else if (busy_m) begin
      rise_cnt++;
      if (rise_cnt >= 17 && !stuck) begin
        out_reg = model_code;
        busy_m <= #1 1'b0;
        t_busy_fall = $realtime + 1.0;
      end
    end
  end

  always @(negedge rd_n) if (rst_n) begin
    chk(busy_m == 1'b0, "R7 read while busy", int'(busy_m), 0);
    chk(($realtime - t_cv_fall) >= real'(POST*CLK_NS), "R7 read after strobe ns",
        int'($realtime - t_cv_fall), POST*CLK_NS);
    chk(cs_n == 1'b0, "R5 chip select low at read", int'(cs_n), 0);
    chk(($realtime - t_rd_rise) >= real'(R_HIGH*CLK_NS), "R6 read high ns",
        int'($realtime - t_rd_rise), R_HIGH*CLK_NS);
    byte_hist = {byte_hist[0], byte_sel};
    t_rd_fall = $realtime;
    rd_count++;
  end

  always @(posedge rd_n) if (rd_count > 0) begin
    chk(int'($realtime - t_rd_fall) == R_LOW*CLK_NS, "R5 read low ns",
        int'($realtime - t_rd_fall), R_LOW*CLK_NS);
    t_rd_rise = $realtime;
  end

  always @(posedge clk) if (valid) valid_count++;

  task automatic pulse_req(input bit m);
    @(negedge clk); req = 1'b1; bmode = m;
    @(negedge clk); req = 1'b0;
  endtask

  task automatic wait_valid(output bit got);
    got = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (valid) begin got = 1'b1; break; end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(convst_n && cs_n && rd_n, "R1 strobes high in reset", int'({convst_n, cs_n, rd_n}), 7);
    chk(!byte_sel && !valid && !err && !cclk, "R1 outputs low in reset",
        int'({byte_sel, valid, err, cclk}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(convst_n && cs_n && rd_n && !valid && !err, "R1 state after reset",
        int'({convst_n, cs_n, rd_n, valid, err}), 28);
  endtask

  task automatic t_clock();
    real t0, t1, t2;
    @(posedge cclk); t0 = $realtime;
    @(negedge cclk); t1 = $realtime;
    @(posedge cclk); t2 = $realtime;
    chk(int'(t1 - t0) == H*CLK_NS, "R2 high phase ns", int'(t1 - t0), H*CLK_NS);
    chk(int'(t2 - t1) == H*CLK_NS, "R2 low phase ns", int'(t2 - t1), H*CLK_NS);
  endtask

  task automatic t_word(input logic [15:0] code);
    int c0, r0, v0; bit got;
    model_code = code; c0 = conv_count; r0 = rd_count; v0 = valid_count;
    pulse_req(1'b0);
    wait_valid(got);
    chk(got, "R8 valid after word conversion", int'(got), 1);
    chk(sample == code, "R5 word result", int'(sample), int'(code));
    chk(err == 1'b0, "R10 error clear after accepted request", int'(err), 0);
    chk(byte_hist[0] == 1'b0, "R5 byte select low in word read", int'(byte_hist[0]), 0);
    @(negedge clk);
    chk(!valid, "R8 valid one cycle", int'(valid), 0);
    chk(conv_count - c0 == 1, "R8 one conversion", conv_count - c0, 1);
    chk(rd_count - r0 == 1, "R5 one read", rd_count - r0, 1);
    chk(valid_count - v0 == 1, "R8 one valid pulse", valid_count - v0, 1);
  endtask

  task automatic t_byte(input logic [15:0] code);
    int r0; bit got;
    model_code = code; r0 = rd_count;
    pulse_req(1'b1);
    bmode = 1'b0;  // R11: change after acceptance has no effect
    wait_valid(got);
    chk(got, "R8 valid after byte conversion", int'(got), 1);
    chk(sample == code, "R6 byte result joined", int'(sample), int'(code));
    chk(byte_hist == 2'b01, "R6 byte select order", int'(byte_hist), 1);
    chk(rd_count - r0 == 2, "R11 mode held, two reads", rd_count - r0, 2);
    @(negedge clk);
    chk(!valid, "R8 valid one cycle", int'(valid), 0);
  endtask

  task automatic t_ignore();
    int c0, v0; bit got;
    model_code = 16'h3C3C; c0 = conv_count; v0 = valid_count;
    pulse_req(1'b0);
    repeat (80) @(negedge clk);
    for (int i = 0; i < 3; i++) begin pulse_req(1'b1); repeat (20) @(negedge clk); end
    wait_valid(got);
    repeat (300) @(negedge clk);
    chk(sample == 16'h3C3C, "R9 result of first request", int'(sample), 16'h3C3C);
    chk(conv_count - c0 == 1, "R9 extra requests ignored", conv_count - c0, 1);
    chk(valid_count - v0 == 1, "R9 one valid only", valid_count - v0, 1);
  endtask

  task automatic t_timeout();
    int r0, v0; bit got;
    stuck = 1'b1; r0 = rd_count; v0 = valid_count;
    pulse_req(1'b0);
    got = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (err) begin got = 1'b1; break; end
    end
    chk(got, "R10 error flag on stuck busy", int'(got), 1);
    chk(cs_n == 1'b1, "R10 chip select released", int'(cs_n), 1);
    chk(rd_count == r0, "R10 no read on timeout", rd_count - r0, 0);
    chk(valid_count == v0, "R10 no valid on timeout", valid_count - v0, 0);
    stuck = 1'b0;
    repeat (100) @(negedge clk);
    chk(err == 1'b1, "R10 error held until next request", int'(err), 1);
  endtask

  initial begin
    t_reset();
    t_clock();
    t_word(16'h1234);
    t_word(16'h8000);
    t_word(16'h7FFF);
    t_word(16'h0000);
    t_word(16'hFFFF);
    t_byte(16'hA55A);
    t_byte(16'h00FF);
    t_byte(16'hFF00);
    t_ignore();
    t_timeout();
    t_word(16'h5AC3);
    t_byte(16'h8001);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R8 watchdog expired: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule